// File: doc/BRIEF.md
# Audio Controller Global Register Block

This block holds the registers that apply to the whole audio controller rather than to one DMA channel. A global control register stores six configuration bits and also acts as the trigger point for warm and cold resets of the codec link. A global status register collects the interrupt levels of the three channel engines (PCM-in, PCM-out and microphone), keeps four sticky link-event flags that software clears by writing ones, and offers two plain read/write bits. A one-bit codec-access semaphore lets software claim the codec: reading it returns the current owner flag and takes ownership in the same access. Any mixer register access releases it.

Software reaches the block through a simple single-cycle register port with byte addresses. The block answers each read one cycle later with a valid strobe. The channel engines feed their interrupt levels in, the mixer decoder signals every mixer access with a pulse, and the link logic raises sticky event pulses. The block drives one-cycle reset pulses towards the link and a combined interrupt line.

Top module: `gs_global_regs`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x00100, the semaphore reads 0, and warm_rst, cold_rst, irq and rd_valid are low.
- R2: A write to the control register (byte address 0x2C) with wdata bit 2 and bit 1 both clear stores wdata[5:0]. The register then reads back that value with bits 31:6 zero.
- R3: A control write with bit 2 set raises warm_rst for exactly one cycle after the write. With bit 1 set, it raises cold_rst for exactly one cycle. In both cases the stored control value is unchanged. A cold reset also returns the semaphore to 0.
- R4: A read of the semaphore (address 0x34) returns its current value in bit 0, with bits 31:1 zero, and then sets the semaphore to 1. An immediate second read therefore returns 1.
- R5: A mixer_access pulse clears the semaphore to 0. This has priority over a semaphore read in the same cycle.
- R6: Every read of the status register (address 0x30) returns bit 8 (codec ready) set.
- R7: Status bits 5, 6 and 7 follow chan_irq[0] (PCM-in), chan_irq[1] (PCM-out) and chan_irq[2] (mic). Each bit sets in the cycle after its input rises and clears in the cycle after it falls. Writes do not change these bits.
- R8: irq is high exactly when any of status bits 7:5 is set.
- R9: sticky_set[0..3] set status bits 0, 10, 11 and 15. Writing 1 to such a bit clears it, and writing 0 leaves it unchanged. A set pulse wins over a clear in the same cycle.
- R10: Writes to read-only status bits 14:12, 9:8, 4:3, 2 and 1 have no effect; those bits read 0 apart from bit 8.
- R11: Status bits 17:16 are plain read/write and hold the last value written.
- R12: rd_valid is high for exactly the one cycle after each read, with rd_data valid. Reads of any other address return 0xFFFFFFFF. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 18 | Write data |
| mixer_access | input | 1 | Pulse on any mixer register access |
| chan_irq | input | 3 | Interrupt levels: PCM-in, PCM-out, mic |
| sticky_set | input | 4 | Link event pulses for the sticky status bits |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| warm_rst | output | 1 | One-cycle warm reset pulse |
| cold_rst | output | 1 | One-cycle cold reset pulse |
| irq | output | 1 | Combined channel interrupt |

## Verification
Each stored field is visible at the read port one cycle after the access that reads it. A wrong bit in the control, status or semaphore state therefore shows up as a read mismatch on the first read that follows. A channel flag stuck in the wrong state also shows on irq one cycle after the channel level changes. A semaphore that fails to take ownership or to release shows on the next semaphore read, which returns the wrong bit 0. A reset trigger that corrupts the stored control value shows on the next control read.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int STA_W        = 18;
  localparam int CTL_W        = 6;
  localparam int NUM_CHAN     = 3;
  localparam int NUM_STICKY   = 4;
  localparam int CHAN_IRQ_LSB = 5;
  localparam int WARM_BIT     = 2;
  localparam int COLD_BIT     = 1;
  localparam int CODEC_RDY_BIT = 8;

  localparam logic [7:0] CTL_OFS = 8'h2C;
  localparam logic [7:0] STA_OFS = 8'h30;
  localparam logic [7:0] SEM_OFS = 8'h34;

  // sticky event bits (write one to clear) and plain read/write bits
  localparam logic [STA_W-1:0] STA_W1C_MASK = 18'h0_8C01;
  localparam logic [STA_W-1:0] STA_RW_MASK  = 18'h3_0000;
  localparam int STICKY_POS [NUM_STICKY] = '{0, 10, 11, 15};

  function automatic logic ctl_is_trigger(input logic [CTL_W-1:0] w);
    return w[WARM_BIT] | w[COLD_BIT];
  endfunction

  // software write: clear W1C ones, load RW bits, keep read-only bits
  function automatic logic [STA_W-1:0] sta_after_write(input logic [STA_W-1:0] old,
                                                       input logic [STA_W-1:0] w);
    logic [STA_W-1:0] r;
    r = old & ~(w & STA_W1C_MASK);
    r = (r & ~STA_RW_MASK) | (w & STA_RW_MASK);
    return r;
  endfunction

  function automatic logic [STA_W-1:0] sta_view(input logic [STA_W-1:0] q);
    logic [STA_W-1:0] r;
    r = q;
    r[CODEC_RDY_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/gs_ctl_reg.sv
module gs_ctl_reg
  import gsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             warm_o,
  output logic             cold_o
);
  logic trig_wr;
  logic store_wr;

  assign trig_wr  = wr_hit & ctl_is_trigger(wdata);
  assign store_wr = wr_hit & ~ctl_is_trigger(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      warm_o <= 1'b0;
      cold_o <= 1'b0;
    end else begin
      if (store_wr) ctl_q <= wdata;
      warm_o <= trig_wr & wdata[WARM_BIT];
      cold_o <= trig_wr & wdata[COLD_BIT];
    end
  end

  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |=> (ctl_q == $past(wdata)));
  // R3
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> $stable(ctl_q));
  // R3
  warm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[WARM_BIT]) |=> warm_o);
endmodule

// File: rtl/gs_sem_reg.sv
module gs_sem_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit,
  input  logic mix_acc,
  input  logic cold_clr,
  output logic sem_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   sem_q <= 1'b0;
    else if (cold_clr || mix_acc) sem_q <= 1'b0;
    else if (rd_hit)              sem_q <= 1'b1;
  end

  // R5
  sem_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mix_acc |=> !sem_q);
  // R4
  sem_acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !mix_acc && !cold_clr) |=> sem_q);
endmodule

// File: rtl/gs_status_reg.sv
module gs_status_reg
  import gsr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hit,
  input  logic [STA_W-1:0]      wdata,
  input  logic [NUM_CHAN-1:0]   chan_irq,
  input  logic [NUM_STICKY-1:0] sticky_set,
  output logic [STA_W-1:0]      sta_q,
  output logic                  irq_o
);
  logic [NUM_CHAN-1:0] chan_prev;
  logic [NUM_CHAN-1:0] chan_rose;
  logic [NUM_CHAN-1:0] chan_fell;
  logic [STA_W-1:0]    sta_nxt;

  assign chan_rose = chan_irq & ~chan_prev;
  assign chan_fell = ~chan_irq & chan_prev;

  always_comb begin
    sta_nxt = sta_q;
    if (wr_hit) sta_nxt = sta_after_write(sta_q, wdata);
    for (int i = 0; i < NUM_STICKY; i++)
      if (sticky_set[i]) sta_nxt[STICKY_POS[i]] = 1'b1;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (chan_rose[c])      sta_nxt[CHAN_IRQ_LSB+c] = 1'b1;
      else if (chan_fell[c]) sta_nxt[CHAN_IRQ_LSB+c] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q     <= '0;
      chan_prev <= '0;
    end else begin
      sta_q     <= sta_nxt;
      chan_prev <= chan_irq;
    end
  end

  assign irq_o = |sta_q[CHAN_IRQ_LSB +: NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan_chk
    // R7
    chan_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_irq[c] |=> sta_q[CHAN_IRQ_LSB+c]);
    // R7
    chan_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_irq[c] |=> !sta_q[CHAN_IRQ_LSB+c]);
  end

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky_chk
    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_set[i] |=> sta_q[STICKY_POS[i]]);
    // R9
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[STICKY_POS[i]] && !sticky_set[i]) |=> !sta_q[STICKY_POS[i]]);
  end

  // R11
  rw_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (sta_q[17:16] == $past(wdata[17:16])));
  // R10
  ro_irq_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (chan_irq == chan_prev)) |=> $stable(sta_q[CHAN_IRQ_LSB +: NUM_CHAN]));
endmodule

// File: rtl/gs_global_regs.sv
module gs_global_regs
  import gsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [STA_W-1:0]      reg_wdata,
  input  logic                  mixer_access,
  input  logic [NUM_CHAN-1:0]   chan_irq,
  input  logic [NUM_STICKY-1:0] sticky_set,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  warm_rst,
  output logic                  cold_rst,
  output logic                  irq
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(STA_OFS);
  localparam logic [ADDR_W-1:0] A_SEM = ADDR_W'(SEM_OFS);

  logic             ctl_wr_hit;
  logic             sta_wr_hit;
  logic             sem_rd_hit;
  logic [CTL_W-1:0] ctl_q;
  logic [STA_W-1:0] sta_q;
  logic             sem_q;
  logic [DATA_W-1:0] rd_next;

  assign ctl_wr_hit = reg_wr && (reg_addr == A_CTL);
  assign sta_wr_hit = reg_wr && (reg_addr == A_STA);
  assign sem_rd_hit = reg_rd && (reg_addr == A_SEM);

  gs_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (ctl_wr_hit),
    .wdata  (reg_wdata[CTL_W-1:0]),
    .ctl_q  (ctl_q),
    .warm_o (warm_rst),
    .cold_o (cold_rst)
  );

  gs_status_reg u_sta (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (sta_wr_hit),
    .wdata      (reg_wdata),
    .chan_irq   (chan_irq),
    .sticky_set (sticky_set),
    .sta_q      (sta_q),
    .irq_o      (irq)
  );

  gs_sem_reg u_sem (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (sem_rd_hit),
    .mix_acc  (mixer_access),
    .cold_clr (cold_rst),
    .sem_q    (sem_q)
  );

  always_comb begin
    rd_next = '1;
    if (reg_addr == A_CTL)      rd_next = DATA_W'(ctl_q);
    else if (reg_addr == A_STA) rd_next = DATA_W'(sta_view(sta_q));
    else if (reg_addr == A_SEM) rd_next = DATA_W'(sem_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_next;
    end
  end

  // R12
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);
  // R6
  codec_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STA) |=> rd_data[CODEC_RDY_BIT]);
endmodule

// File: tb/gs_global_regs_tb.sv
module gs_global_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTL = 6'h2C;
  localparam logic [5:0] A_STA = 6'h30;
  localparam logic [5:0] A_SEM = 6'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [17:0] reg_wdata = '0;
  logic        mixer_access = 1'b0;
  logic [2:0]  chan_irq = '0;
  logic [3:0]  sticky_set = '0;
  logic [31:0] rd_data;
  logic        rd_valid, warm_rst, cold_rst, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gs_global_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mixer_access(mixer_access),
    .chan_irq(chan_irq), .sticky_set(sticky_set), .rd_data(rd_data),
    .rd_valid(rd_valid), .warm_rst(warm_rst), .cold_rst(cold_rst), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare each returned read with the queued expectation
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R12 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [5:0] a, input logic [17:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 warm_rst", 32'(warm_rst), 0);
    check("R1 cold_rst", 32'(cold_rst), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 rd_valid", 32'(rd_valid), 0);
    rd(A_CTL, 32'h0, "R1 ctl reset");
    rd(A_STA, 32'h100, "R1/R6 status reset");
    rd(A_SEM, 32'h0, "R1/R4 sem first read");
    rd(A_SEM, 32'h1, "R4 sem second read");
    @(negedge clk); check("R12 rd_valid one cycle", 32'(rd_valid), 0);
    @(negedge clk); mixer_access = 1'b1;
    @(negedge clk); mixer_access = 1'b0;
    rd(A_SEM, 32'h0, "R5 sem released by mixer access");

    // control register
    wr(A_CTL, 18'h3FFF9);
    rd(A_CTL, 32'h39, "R2 ctl store");
    wr(A_CTL, 18'h00004);
    check("R3 warm pulse", 32'(warm_rst), 1);
    check("R3 no cold on warm", 32'(cold_rst), 0);
    @(negedge clk);
    check("R3 warm one cycle", 32'(warm_rst), 0);
    rd(A_CTL, 32'h39, "R3 ctl unchanged by warm");
    wr(A_CTL, 18'h00002);
    check("R3 cold pulse", 32'(cold_rst), 1);
    @(negedge clk);
    check("R3 cold one cycle", 32'(cold_rst), 0);
    rd(A_SEM, 32'h0, "R3 cold clears sem");
    rd(A_CTL, 32'h39, "R3 ctl unchanged by cold");

    // channel interrupts
    @(negedge clk); chan_irq = 3'b010;
    @(negedge clk); check("R8 irq on pcm-out", 32'(irq), 1);
    rd(A_STA, 32'h140, "R7 pcm-out flag");
    @(negedge clk); chan_irq = 3'b000;
    @(negedge clk); check("R8 irq cleared", 32'(irq), 0);
    @(negedge clk); chan_irq = 3'b101;
    @(negedge clk); check("R8 irq on in+mic", 32'(irq), 1);
    wr(A_STA, 18'h000E0);
    rd(A_STA, 32'h1A0, "R7 in+mic flags, write ignored");
    @(negedge clk); chan_irq = 3'b000;
    @(negedge clk);
    rd(A_STA, 32'h100, "R7 flags cleared");

    // sticky bits
    @(negedge clk); sticky_set = 4'hF;
    @(negedge clk); sticky_set = 4'h0;
    rd(A_STA, 32'h8D01, "R9 sticky set");
    wr(A_STA, 18'h00401);
    rd(A_STA, 32'h8900, "R9 sticky w1c");
    wr(A_STA, 18'h00000);
    rd(A_STA, 32'h8900, "R9 write zero no effect");
    @(negedge clk);
    sticky_set = 4'b1000; reg_wr = 1'b1; reg_addr = A_STA; reg_wdata = 18'h08000;
    @(negedge clk);
    sticky_set = 4'h0; reg_wr = 1'b0;
    rd(A_STA, 32'h8900, "R9 set wins over clear");
    wr(A_STA, 18'h08800);
    rd(A_STA, 32'h100, "R9 sticky cleared");

    // read-only and read/write bits
    wr(A_STA, 18'h073FE);
    rd(A_STA, 32'h100, "R10 read-only bits ignore writes");
    wr(A_STA, 18'h30000);
    rd(A_STA, 32'h30100, "R11 rw bits set");
    wr(A_STA, 18'h10000);
    rd(A_STA, 32'h10100, "R11 rw bits update");

    // unmapped
    rd(6'h00, 32'hFFFFFFFF, "R12 unmapped read");
    wr(6'h00, 18'h00000);
    rd(A_CTL, 32'h39, "R12 unmapped write no effect");

    repeat (3) @(negedge clk);
    check("R12 all reads answered", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule